// File: doc/BRIEF.md
# UART Enable and Reset Command Sequencer

This block turns writes to a 32-bit, write-only UART command word into actions on the transmit and receive engines. Each set bit is a one-shot command: enable or disable a direction, abort it at once, clear the sticky error and match flags, or drop a pending clock or wake request. Bits written as zero do nothing, so software only touches the functions it names.

A disable is graceful. The direction enters a stopping state and keeps its enable high until its engine is idle. For the transmitter, idle means no character is shifting and the holding register is empty. A reset bit for the same direction aborts at once and overrides both disable and enable. When enable and disable arrive in the same write, disable wins.

Top module: `uart_ctl_seq`

## Requirements
- R1: After rst_ni is released, tx_en_o and rx_en_o are 0, the stopping flags are 0, and no pulse output is high.
- R2: A write with bit 6 set turns tx_en_o on in the next cycle, and a write with bit 4 set turns rx_en_o on in the next cycle, provided the same write does not also set the direction's disable bit or reset bit.
- R3: If a write sets both the enable bit and the disable bit of a direction (bits 6/7 for transmit, bits 4/5 for receive), the disable is applied and the enable is dropped.
- R4: Bit 7 on a running transmitter holds tx_en_o high with tx_stopping_o set while tx_busy_i or tx_hold_i is 1. tx_en_o falls one cycle after the first clock edge at which both inputs are 0. If the engine is already idle, it falls in the cycle after the write.
- R5: Bit 5 on a running receiver holds rx_en_o high with rx_stopping_o set while rx_busy_i is 1. rx_en_o falls one cycle after the first clock edge at which rx_busy_i is 0.
- R6: Bit 3 gives a one-cycle tx_abort_o pulse in the cycle after the write and clears tx_en_o in that same cycle, even if the direction was stopping or the write also set bit 6 or bit 7.
- R7: Bit 2 gives a one-cycle rx_abort_o pulse in the cycle after the write and clears rx_en_o in that same cycle, with the same override as R6.
- R8: Bit 8 gives a one-cycle sts_clr_o pulse in the cycle after the write. This pulse clears the parity, framing, compare-match and overrun flags.
- R9: Bit 12 gives one-cycle wake_clr_o and cmp_rearm_o pulses in the cycle after the write.
- R10: Bits 0, 1, 9, 10, 11 and 13 to 31 change no output. Data presented while wr_i is 0 changes no output.
- R11: A write with the enable bit alone, while a direction is stopping, returns it to running: the enable stays high and the stopping flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Command write strobe |
| wdata_i | input | 32 | Command word |
| tx_busy_i | input | 1 | Transmitter is shifting a character |
| tx_hold_i | input | 1 | Transmit holding register has a character waiting |
| rx_busy_i | input | 1 | Receiver is taking in a character |
| tx_en_o | output | 1 | Transmitter enabled |
| rx_en_o | output | 1 | Receiver enabled |
| tx_stopping_o | output | 1 | Transmitter is draining before it stops |
| rx_stopping_o | output | 1 | Receiver is draining before it stops |
| tx_abort_o | output | 1 | Transmitter reset pulse |
| rx_abort_o | output | 1 | Receiver reset pulse |
| sts_clr_o | output | 1 | Status flag clear pulse |
| wake_clr_o | output | 1 | Clock or wake request cancel pulse |
| cmp_rearm_o | output | 1 | Receive compare trigger re-arm pulse |

## Verification
The command word is tried in several forms. Single command bits show that each bit maps to its own output. Enable and disable together show which one has priority. Reset combined with disable shows that abort beats graceful stop. A word with every unused bit set, and data held without a strobe, show that nothing leaks through. The graceful paths are driven with busy, then hold-only, then idle engine states. This separates waiting on the shifter from waiting on the holding register, and it pins the exact cycle in which the enable falls. A reset issued during stopping, and an enable issued during stopping, show that each can cut the drain short.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;
  typedef enum logic [1:0] {
    DIR_OFF  = 2'd0,
    DIR_RUN  = 2'd1,
    DIR_STOP = 2'd2
  } dir_state_e;

  typedef struct packed {
    logic rst;
    logic en;
    logic dis;
  } dir_cmd_t;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_TX  = 0;
  localparam int unsigned DIR_RX  = 1;
endpackage

// File: rtl/uart_ctl_decode.sv
module uart_ctl_decode
  import uart_ctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned B_RX_RST  = 2,
  parameter int unsigned B_TX_RST  = 3,
  parameter int unsigned B_RX_EN   = 4,
  parameter int unsigned B_RX_DIS  = 5,
  parameter int unsigned B_TX_EN   = 6,
  parameter int unsigned B_TX_DIS  = 7,
  parameter int unsigned B_STS_CLR = 8,
  parameter int unsigned B_REQ_CLR = 12
) (
  input  logic                      wr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output dir_cmd_t [NUM_DIR-1:0]    cmd_o,
  output logic                      sts_clr_o,
  output logic                      req_clr_o
);
  always_comb begin
    cmd_o[DIR_TX].rst = wr_i & wdata_i[B_TX_RST];
    cmd_o[DIR_TX].en  = wr_i & wdata_i[B_TX_EN];
    cmd_o[DIR_TX].dis = wr_i & wdata_i[B_TX_DIS];
    cmd_o[DIR_RX].rst = wr_i & wdata_i[B_RX_RST];
    cmd_o[DIR_RX].en  = wr_i & wdata_i[B_RX_EN];
    cmd_o[DIR_RX].dis = wr_i & wdata_i[B_RX_DIS];
    sts_clr_o         = wr_i & wdata_i[B_STS_CLR];
    req_clr_o         = wr_i & wdata_i[B_REQ_CLR];
  end
endmodule

// File: rtl/uart_ctl_dir.sv
module uart_ctl_dir
  import uart_ctl_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dir_cmd_t cmd_i,
  input  logic     idle_i,
  output logic     en_o,
  output logic     stopping_o,
  output logic     abort_o
);
  dir_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (cmd_i.rst) begin
      state_d = DIR_OFF;
    end else if (cmd_i.dis) begin
      // disable dominates enable; drain if engine still has work
      if (state_q != DIR_OFF) state_d = idle_i ? DIR_OFF : DIR_STOP;
    end else if (cmd_i.en) begin
      state_d = DIR_RUN;
    end else if (state_q == DIR_STOP && idle_i) begin
      state_d = DIR_OFF;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DIR_OFF;
      abort_o <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_o <= cmd_i.rst;
    end
  end

  assign en_o       = (state_q != DIR_OFF);
  assign stopping_o = (state_q == DIR_STOP);
endmodule

// File: rtl/uart_ctl_flags.sv
module uart_ctl_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sts_clr_i,
  input  logic req_clr_i,
  output logic sts_clr_o,
  output logic wake_clr_o,
  output logic cmp_rearm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sts_clr_o   <= 1'b0;
      wake_clr_o  <= 1'b0;
      cmp_rearm_o <= 1'b0;
    end else begin
      sts_clr_o   <= sts_clr_i;
      wake_clr_o  <= req_clr_i;
      cmp_rearm_o <= req_clr_i;
    end
  end
endmodule

// File: rtl/uart_ctl_seq.sv
module uart_ctl_seq
  import uart_ctl_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned B_RX_RST  = 2,
  parameter int unsigned B_TX_RST  = 3,
  parameter int unsigned B_RX_EN   = 4,
  parameter int unsigned B_RX_DIS  = 5,
  parameter int unsigned B_TX_EN   = 6,
  parameter int unsigned B_TX_DIS  = 7,
  parameter int unsigned B_STS_CLR = 8,
  parameter int unsigned B_REQ_CLR = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              tx_busy_i,
  input  logic              tx_hold_i,
  input  logic              rx_busy_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic              tx_stopping_o,
  output logic              rx_stopping_o,
  output logic              tx_abort_o,
  output logic              rx_abort_o,
  output logic              sts_clr_o,
  output logic              wake_clr_o,
  output logic              cmp_rearm_o
);
  dir_cmd_t [NUM_DIR-1:0] cmd;
  logic     [NUM_DIR-1:0] idle, en, stopping, abort;
  logic                   sts_clr, req_clr;

  uart_ctl_decode #(
    .DATA_W(DATA_W), .B_RX_RST(B_RX_RST), .B_TX_RST(B_TX_RST),
    .B_RX_EN(B_RX_EN), .B_RX_DIS(B_RX_DIS), .B_TX_EN(B_TX_EN),
    .B_TX_DIS(B_TX_DIS), .B_STS_CLR(B_STS_CLR), .B_REQ_CLR(B_REQ_CLR)
  ) u_decode (
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .cmd_o    (cmd),
    .sts_clr_o(sts_clr),
    .req_clr_o(req_clr)
  );

  // transmitter drains shifter and holding register, receiver only shifter
  assign idle[DIR_TX] = ~tx_busy_i & ~tx_hold_i;
  assign idle[DIR_RX] = ~rx_busy_i;

  for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
    uart_ctl_dir u_dir (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cmd_i     (cmd[d]),
      .idle_i    (idle[d]),
      .en_o      (en[d]),
      .stopping_o(stopping[d]),
      .abort_o   (abort[d])
    );
  end

  uart_ctl_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sts_clr_i  (sts_clr),
    .req_clr_i  (req_clr),
    .sts_clr_o  (sts_clr_o),
    .wake_clr_o (wake_clr_o),
    .cmp_rearm_o(cmp_rearm_o)
  );

  assign tx_en_o       = en[DIR_TX];
  assign rx_en_o       = en[DIR_RX];
  assign tx_stopping_o = stopping[DIR_TX];
  assign rx_stopping_o = stopping[DIR_RX];
  assign tx_abort_o    = abort[DIR_TX];
  assign rx_abort_o    = abort[DIR_RX];
endmodule

// File: rtl/uart_ctl_seq_chk.sv
module uart_ctl_seq_chk #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned B_RX_RST  = 2,
  parameter int unsigned B_TX_RST  = 3,
  parameter int unsigned B_RX_EN   = 4,
  parameter int unsigned B_RX_DIS  = 5,
  parameter int unsigned B_TX_EN   = 6,
  parameter int unsigned B_TX_DIS  = 7,
  parameter int unsigned B_STS_CLR = 8,
  parameter int unsigned B_REQ_CLR = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              tx_busy_i,
  input logic              tx_hold_i,
  input logic              rx_busy_i,
  input logic              tx_en_o,
  input logic              rx_en_o,
  input logic              tx_stopping_o,
  input logic              rx_stopping_o,
  input logic              tx_abort_o,
  input logic              rx_abort_o,
  input logic              sts_clr_o,
  input logic              wake_clr_o,
  input logic              cmp_rearm_o
);
  // R2
  tx_en_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_en_o) |-> $past(wr_i && wdata_i[B_TX_EN] && !wdata_i[B_TX_DIS] && !wdata_i[B_TX_RST]));
  // R3
  tx_dis_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_TX_EN] && wdata_i[B_TX_DIS] && !tx_en_o) |=> !tx_en_o);
  // R4
  tx_drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_en_o && (tx_busy_i || tx_hold_i) && !(wr_i && wdata_i[B_TX_RST])) |=> tx_en_o);
  // R5
  rx_drain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_en_o && rx_busy_i && !(wr_i && wdata_i[B_RX_RST])) |=> rx_en_o);
  // R6
  tx_abort_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_TX_RST]) |=> (tx_abort_o && !tx_en_o));
  // R7
  rx_abort_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_RX_RST]) |=> (rx_abort_o && !rx_en_o));
  // R8
  sts_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_STS_CLR]) |=> sts_clr_o);
  // R9
  req_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wdata_i[B_REQ_CLR]) |=> (wake_clr_o && cmp_rearm_o));
  // R10
  no_wr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> !(tx_abort_o || rx_abort_o || sts_clr_o || wake_clr_o || cmp_rearm_o));
  // R4
  stop_implies_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_stopping_o |-> tx_en_o);
endmodule

bind uart_ctl_seq uart_ctl_seq_chk #(
  .DATA_W(DATA_W), .B_RX_RST(B_RX_RST), .B_TX_RST(B_TX_RST),
  .B_RX_EN(B_RX_EN), .B_RX_DIS(B_RX_DIS), .B_TX_EN(B_TX_EN),
  .B_TX_DIS(B_TX_DIS), .B_STS_CLR(B_STS_CLR), .B_REQ_CLR(B_REQ_CLR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
  .tx_busy_i(tx_busy_i), .tx_hold_i(tx_hold_i), .rx_busy_i(rx_busy_i),
  .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .tx_stopping_o(tx_stopping_o),
  .rx_stopping_o(rx_stopping_o), .tx_abort_o(tx_abort_o), .rx_abort_o(rx_abort_o),
  .sts_clr_o(sts_clr_o), .wake_clr_o(wake_clr_o), .cmp_rearm_o(cmp_rearm_o)
);

// File: tb/uart_ctl_seq_test.sv
module uart_ctl_seq_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic        tx_busy_i = 1'b0, tx_hold_i = 1'b0, rx_busy_i = 1'b0;
  logic        tx_en_o, rx_en_o, tx_stopping_o, rx_stopping_o;
  logic        tx_abort_o, rx_abort_o, sts_clr_o, wake_clr_o, cmp_rearm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  uart_ctl_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .tx_busy_i(tx_busy_i), .tx_hold_i(tx_hold_i), .rx_busy_i(rx_busy_i),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .tx_stopping_o(tx_stopping_o),
    .rx_stopping_o(rx_stopping_o), .tx_abort_o(tx_abort_o), .rx_abort_o(rx_abort_o),
    .sts_clr_o(sts_clr_o), .wake_clr_o(wake_clr_o), .cmp_rearm_o(cmp_rearm_o)
  );

  // {wdata, tx_busy, tx_hold, rx_busy, exp{tx_en,rx_en,tx_abort,rx_abort,sts,wake,rearm}}
  localparam int NV = 11;
  localparam logic [41:0] VEC [NV] = '{
    {32'h0000_0040, 3'b100, 7'b1000000},
    {32'h0000_0010, 3'b000, 7'b1100000},
    {32'hFFFF_EE03, 3'b000, 7'b1100000},
    {32'h0000_0100, 3'b000, 7'b1100100},
    {32'h0000_1000, 3'b000, 7'b1100011},
    {32'h0000_0008, 3'b000, 7'b0110000},
    {32'h0000_00C0, 3'b000, 7'b0100000},
    {32'h0000_0030, 3'b000, 7'b0000000},
    {32'h0000_0024, 3'b000, 7'b0001000},
    {32'h0000_0050, 3'b000, 7'b1100000},
    {32'h0000_000C, 3'b000, 7'b0011000}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 1, 9: return "R2";
      2:       return "R10";
      3:       return "R8";
      4:       return "R9";
      5, 10:   return "R6";
      6, 7:    return "R3";
      8:       return "R7";
      default: return "R?";
    endcase
  endfunction

  function automatic logic [6:0] outs();
    return {tx_en_o, rx_en_o, tx_abort_o, rx_abort_o, sts_clr_o, wake_clr_o, cmp_rearm_o};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive one write; return at the negedge after the capturing edge
  task automatic do_write(logic [31:0] d);
    @(negedge clk_i);
    wr_i = 1'b1;
    wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    wdata_i = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1", {tx_stopping_o, rx_stopping_o, outs()}, 9'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {tx_busy_i, tx_hold_i, rx_busy_i} = VEC[i][9:7];
      do_write(VEC[i][41:10]);
      chk(vec_tag(i), {25'h0, outs()}, {25'h0, VEC[i][6:0]});
    end
    tx_busy_i = 1'b0;
    // pulses last one cycle (R6)
    @(negedge clk_i);
    chk("R6", {30'h0, tx_abort_o, rx_abort_o}, 32'h0);

    // R10 data without strobe
    wdata_i = 32'h0000_1150;
    @(negedge clk_i);
    @(negedge clk_i);
    chk("R10", {25'h0, outs()}, 32'h0);
    wdata_i = '0;

    // R4 graceful tx stop: shifter busy, then hold only, then idle
    do_write(32'h40);
    tx_busy_i = 1'b1;
    tx_hold_i = 1'b1;
    do_write(32'h80);
    chk("R4", {30'h0, tx_en_o, tx_stopping_o}, 32'h3);
    repeat (3) @(negedge clk_i);
    chk("R4", {30'h0, tx_en_o, tx_stopping_o}, 32'h3);
    tx_busy_i = 1'b0;
    @(negedge clk_i);
    chk("R4", {31'h0, tx_en_o}, 32'h1);
    tx_hold_i = 1'b0;
    @(negedge clk_i);
    chk("R4", {30'h0, tx_en_o, tx_stopping_o}, 32'h0);
    // R4 idle disable drops next cycle
    do_write(32'h40);
    do_write(32'h80);
    chk("R4", {31'h0, tx_en_o}, 32'h0);

    // R5 graceful rx stop
    do_write(32'h10);
    rx_busy_i = 1'b1;
    do_write(32'h20);
    repeat (2) @(negedge clk_i);
    chk("R5", {30'h0, rx_en_o, rx_stopping_o}, 32'h3);
    rx_busy_i = 1'b0;
    @(negedge clk_i);
    chk("R5", {30'h0, rx_en_o, rx_stopping_o}, 32'h0);

    // R11 enable during stopping resumes
    do_write(32'h10);
    rx_busy_i = 1'b1;
    do_write(32'h20);
    do_write(32'h10);
    chk("R11", {30'h0, rx_en_o, rx_stopping_o}, 32'h2);
    rx_busy_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk("R11", {31'h0, rx_en_o}, 32'h1);

    // R7 reset aborts a draining receiver
    rx_busy_i = 1'b1;
    do_write(32'h20);
    do_write(32'h04);
    chk("R7", {29'h0, rx_en_o, rx_stopping_o, rx_abort_o}, 32'h1);
    rx_busy_i = 1'b0;

    // R6 reset with disable while busy aborts at once
    do_write(32'h40);
    tx_busy_i = 1'b1;
    do_write(32'h88);
    chk("R6", {29'h0, tx_en_o, tx_stopping_o, tx_abort_o}, 32'h1);
    tx_busy_i = 1'b0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule